// File: doc/BRIEF.md
# ALU with Status Flag Register

This block is the arithmetic core of a small 8-bit processor together with its status register. Each cycle it combines a working operand and a file operand under a 4-bit operation code. It presents the result combinationally, and on a clock edge where `exec` is high it updates the zero, digit-carry and carry flags. Only the flags that the operation touches are updated.

The status register also holds the three bank-select bits and two read-only supervision bits. The time-out bit (bit 4) and the power-down bit (bit 3) move only on reset and on three event strobes: watchdog clear, sleep entry and watchdog expiry. When the instruction names the status register as its destination (`dest_status`), the result is written into it. Flag bits driven by the flag logic are protected from that data write, and bits 4 and 3 are never written by data.

Status bit order, from bit 7 down to bit 0: two reserved bank bits, bank select, time-out, power-down, Z, DC, C.

Top module: `alu_status`

## Requirements
- R1: Operation code 0 gives f + w. C is the carry out of bit 7 and DC is the carry out of bit 3.
- R2: Operation code 1 gives f - w, computed as f plus the two's complement of w. C = 1 when f >= w and DC = 1 when f[3:0] >= w[3:0]; both read as "no borrow".
- R3: Z is set exactly when the result is zero for codes 0, 1, 2 (AND), 3 (OR), 4 (XOR) and 9 (clear, result 0). Codes 2, 3, 4 and 9 leave DC and C unchanged.
- R4: Code 5 rotates f left through carry and code 6 rotates it right through carry. C takes the bit shifted out, the old C enters at the other end, and Z and DC are unchanged.
- R5: Code 7 swaps the nibbles of f, code 8 passes w, and codes 10 to 15 pass f. None of these codes changes a flag.
- R6: When `dest_status` is set with an operation that affects flags, bits 7:5 take the result. Flags the operation affects take the flag logic values, flags it does not affect keep their value, and bits 4:3 are unchanged. Clearing the status register therefore leaves 000uu1uu.
- R7: When `dest_status` is set with an operation that affects no flag, bits 7:5 and 2:0 take the result and bits 4:3 are unchanged.
- R8: Expiry clears time-out. Sleep or clear (without expiry) sets time-out. Sleep clears power-down. Clear without sleep sets power-down. With no event strobe both bits hold.
- R9: Reset (active low) puts the status register to 0x18: time-out and power-down set, all other bits clear.
- R10: `bank_sel` equals status bit 5. With `exec` low and no event strobe, the status register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| op | input | 4 | Operation code |
| w_in | input | 8 | Working operand |
| f_in | input | 8 | File operand |
| dest_status | input | 1 | Result is written to the status register |
| exec | input | 1 | Instruction executes this cycle |
| ev_wdt_clear | input | 1 | Watchdog clear strobe |
| ev_sleep | input | 1 | Sleep entry strobe |
| ev_wdt_timeout | input | 1 | Watchdog expiry strobe |
| result | output | 8 | ALU result |
| status | output | 8 | Status register |
| bank_sel | output | 1 | Data-memory bank select |

## Verification
The bench targets several corner cases:
- Subtraction with equal operands and with a borrow in only one nibble. A design with carry polarity not inverted for subtract would report borrow where none occurred.
- Clearing the status register while DC and C are set. A design that lets data reach the flags would zero DC and C, and one that lets data reach the supervision bits would zero time-out and power-down.
- Rotates with the carry set. A design that fills from zero instead of from the old carry would show a wrong top or bottom bit.
- Simultaneous event strobes, which expose a wrong order of precedence between expiry, sleep and clear.

// File: rtl/alu_status.sv
module alu_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op,
  input  logic [DW-1:0] w_in,
  input  logic [DW-1:0] f_in,
  input  logic          dest_status,
  input  logic          exec,
  input  logic          ev_wdt_clear,
  input  logic          ev_sleep,
  input  logic          ev_wdt_timeout,
  output logic [DW-1:0] result,
  output logic [7:0]    status,
  output logic          bank_sel
);
  localparam int NH = DW / 2;
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_IOR = 4'd3,
                         OP_XOR = 4'd4, OP_RLF = 4'd5, OP_RRF = 4'd6, OP_SWAP = 4'd7,
                         OP_MOVW = 4'd8, OP_CLR = 4'd9;

  logic [7:0]    st;
  logic [DW-1:0] res;
  logic [2:0]    aff;
  logic          c_new;

  wire          is_sub = (op == OP_SUB);
  wire [DW-1:0] b      = is_sub ? ~w_in : w_in;
  wire [DW:0]   sum    = {1'b0, f_in} + {1'b0, b} + {{DW{1'b0}}, is_sub};

  always_comb begin
    res   = f_in;
    aff   = 3'b000;
    c_new = st[0];
    case (op)
      OP_ADD, OP_SUB: begin res = sum[DW-1:0]; aff = 3'b111; c_new = sum[DW]; end
      OP_AND:  begin res = f_in & w_in; aff = 3'b100; end
      OP_IOR:  begin res = f_in | w_in; aff = 3'b100; end
      OP_XOR:  begin res = f_in ^ w_in; aff = 3'b100; end
      OP_RLF:  begin res = {f_in[DW-2:0], st[0]}; aff = 3'b001; c_new = f_in[DW-1]; end
      OP_RRF:  begin res = {st[0], f_in[DW-1:1]}; aff = 3'b001; c_new = f_in[0]; end
      OP_SWAP: res = {f_in[NH-1:0], f_in[DW-1:NH]};
      OP_MOVW: res = w_in;
      OP_CLR:  begin res = '0; aff = 3'b100; end
      default: res = f_in;
    endcase
  end

  wire       z_new  = (res == '0);
  wire       dc_new = f_in[NH] ^ b[NH] ^ sum[NH];
  wire [2:0] flg    = {z_new, dc_new, c_new};
  wire [2:0] upd    = (aff & flg) | (~aff & st[2:0]);

  wire to_nx = ev_wdt_timeout ? 1'b0 : (ev_sleep | ev_wdt_clear) ? 1'b1 : st[4];
  wire pd_nx = ev_sleep ? 1'b0 : ev_wdt_clear ? 1'b1 : st[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= 8'h18;
    end else begin
      st[4] <= to_nx;
      st[3] <= pd_nx;
      if (exec) begin
        if (dest_status) begin
          st[7:5] <= res[7:5];
          st[2:0] <= (|aff) ? upd : res[2:0];
        end else begin
          st[2:0] <= upd;
        end
      end
    end
  end

  assign result   = res;
  assign status   = st;
  assign bank_sel = st[5];
endmodule

module alu_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op,
  input logic [7:0] w_in,
  input logic [7:0] f_in,
  input logic       dest_status,
  input logic       exec,
  input logic       ev_wdt_clear,
  input logic       ev_sleep,
  input logic       ev_wdt_timeout,
  input logic [7:0] status,
  input logic       bank_sel
);
  wire no_ev = !(ev_wdt_clear || ev_sleep || ev_wdt_timeout);

  assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exec && !dest_status && op == 4'd0 |=> status[0] == ($past({1'b0, f_in}) + $past({1'b0, w_in}) > 9'd255));
  assert_sub_noborrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec && !dest_status && op == 4'd1 |=> status[0] == ($past(f_in) >= $past(w_in)));
  assert_rlf_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec && !dest_status && op == 4'd5 |=> status[0] == $past(f_in[7]));
  assert_swap_noflags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == 4'd7 && !dest_status |=> $stable(status[2:0]));
  assert_clr_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec && dest_status && op == 4'd9 |=> status[7:5] == 3'b000 && status[2] && $stable(status[1:0]));
  assert_movw_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec && dest_status && op == 4'd8 |=> {status[7:5], status[2:0]} == $past({w_in[7:5], w_in[2:0]}));
  assert_sleep_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sleep |=> !status[3]);
  assert_timeout_to_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt_timeout |=> !status[4]);
  assert_sup_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    no_ev |=> $stable(status[4:3]));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !exec && no_ev |=> $stable(status));
  assert_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel == status[5]);
endmodule

bind alu_status alu_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .w_in(w_in), .f_in(f_in),
  .dest_status(dest_status), .exec(exec), .ev_wdt_clear(ev_wdt_clear),
  .ev_sleep(ev_sleep), .ev_wdt_timeout(ev_wdt_timeout),
  .status(status), .bank_sel(bank_sel)
);

// File: tb/sim_alu_status.sv
module sim_alu_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] w_in = '0, f_in = '0;
  logic dest_status = 1'b0, exec = 1'b0;
  logic ev_wdt_clear = 1'b0, ev_sleep = 1'b0, ev_wdt_timeout = 1'b0;
  logic [7:0] result, status;
  logic bank_sel;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m_st;

  always #5 clk = ~clk;

  alu_status u0 (.*);

  // returns {affected ZDCC, Z, DC, C, result}
  function automatic logic [13:0] ref_alu(input logic [3:0] o, input logic [7:0] w, input logic [7:0] f, input logic cin);
    int s;
    logic [7:0] r;
    logic [2:0] a;
    logic c, dc;
    r = f; a = 3'b000; c = cin; dc = 1'b0;
    case (o)
      4'd0: begin s = int'(f) + int'(w); r = s[7:0]; c = s > 255; dc = (f % 16 + w % 16) > 15; a = 3'b111; end
      4'd1: begin r = f - w; c = f >= w; dc = (f % 16) >= (w % 16); a = 3'b111; end
      4'd2: begin r = f & w; a = 3'b100; end
      4'd3: begin r = f | w; a = 3'b100; end
      4'd4: begin r = f ^ w; a = 3'b100; end
      4'd5: begin r = (f << 1) | {7'd0, cin}; c = f[7]; a = 3'b001; end
      4'd6: begin r = (f >> 1) | {cin, 7'd0}; c = f[0]; a = 3'b001; end
      4'd7: r = {f[3:0], f[7:4]};
      4'd8: r = w;
      4'd9: begin r = 8'd0; a = 3'b100; end
      default: r = f;
    endcase
    return {a, r == 8'd0, dc, c, r};
  endfunction

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4, 4'd9: return "R3";
      4'd5, 4'd6: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [7:0] w, input logic [7:0] f,
                      input logic dst, input logic ex, input logic ec, input logic es, input logic et);
    logic [13:0] m;
    logic [2:0] a, nf;
    logic [7:0] nx;
    string tg;
    @(negedge clk);
    op = o; w_in = w; f_in = f; dest_status = dst; exec = ex;
    ev_wdt_clear = ec; ev_sleep = es; ev_wdt_timeout = et;
    #1;
    m = ref_alu(o, w, f, m_st[0]);
    check(op_tag(o), result, m[7:0]);
    a = m[13:11];
    nf = (a & m[10:8]) | (~a & m_st[2:0]);
    nx = m_st;
    if (et) nx[4] = 1'b0; else if (es || ec) nx[4] = 1'b1;
    if (es) nx[3] = 1'b0; else if (ec) nx[3] = 1'b1;
    if (ex) begin
      if (dst) begin
        nx[7:5] = m[7:5];
        nx[2:0] = (|a) ? nf : m[2:0];
      end else nx[2:0] = nf;
    end
    if (ex && dst) tg = (|a) ? "R6" : "R7";
    else if (ec || es || et) tg = "R8";
    else if (ex) tg = op_tag(o);
    else tg = "R10";
    m_st = nx;
    @(posedge clk); #1;
    check(tg, status, m_st);
    check("R10", {7'd0, bank_sel}, {7'd0, m_st[5]});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_st = 8'h18;
    repeat (3) @(negedge clk);
    check("R9", status, 8'h18);
    rst_n = 1'b1;
    // directed
    step(4'd0, 8'h80, 8'h80, 0, 1, 0, 0, 0);   // R1 zero with carry
    step(4'd0, 8'h0F, 8'h01, 0, 1, 0, 0, 0);   // R1 digit carry
    step(4'd1, 8'h42, 8'h42, 0, 1, 0, 0, 0);   // R2 equal: Z, C, DC set
    step(4'd1, 8'h01, 8'h10, 0, 1, 0, 0, 0);   // R2 nibble borrow only
    step(4'd1, 8'h20, 8'h10, 0, 1, 0, 0, 0);   // R2 full borrow
    step(4'd0, 8'hFF, 8'h01, 0, 1, 0, 0, 0);   // set C, DC, Z
    step(4'd5, 8'h00, 8'h40, 0, 1, 0, 0, 0);   // R4 old C enters bit 0
    step(4'd0, 8'hFF, 8'h01, 0, 1, 0, 0, 0);
    step(4'd6, 8'h00, 8'h02, 0, 1, 0, 0, 0);   // R4 old C enters bit 7
    step(4'd0, 8'hFF, 8'h01, 0, 1, 0, 0, 0);
    step(4'd9, 8'h00, 8'hAA, 1, 1, 0, 0, 0);   // R6 clear into status, 000uu1uu
    step(4'd8, 8'hFF, 8'h00, 1, 1, 0, 0, 0);   // R7 bits 4:3 protected
    step(4'd8, 8'h20, 8'h00, 1, 1, 0, 0, 0);   // R7/R10 bank select
    step(4'd7, 8'h00, 8'h00, 0, 1, 0, 0, 0);   // R5 swap of zero, Z unchanged
    step(4'd0, 8'h00, 8'h00, 0, 0, 0, 1, 0);   // R8 sleep
    step(4'd0, 8'h00, 8'h00, 0, 0, 0, 0, 1);   // R8 timeout
    step(4'd0, 8'h00, 8'h00, 0, 0, 1, 0, 0);   // R8 clear
    step(4'd0, 8'h00, 8'h00, 0, 0, 1, 1, 1);   // R8 all strobes
    step(4'd1, 8'h00, 8'h00, 0, 0, 0, 0, 0);   // R10 idle hold
    // random
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ro;
      logic [7:0] rw, rf;
      logic rd, rx, rc, rs, rt;
      ro = 4'($urandom); rw = 8'($urandom); rf = 8'($urandom);
      if ($urandom % 8 == 0) rw = rf;
      rd = ($urandom % 5) == 0; rx = ($urandom % 6) != 0;
      rc = ($urandom % 10) == 0; rs = ($urandom % 12) == 0; rt = ($urandom % 12) == 0;
      step(ro, rw, rf, rd, rx, rc, rs, rt);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule